// File: doc/BRIEF.md
# Serial Two's Complement Negator

This block negates a binary number that arrives one bit per clock, least significant bit first, and returns the negated value on a single output wire in the same bit order. It does not use an adder. Up to and including the first 1 it sees, it passes each input bit through unchanged. From the bit after that 1 onward, it sends out the complement of each input bit.

The core is a four-state Moore machine. Its state is held in two flops: a sticky flag that records whether a 1 has already passed through, and the output bit itself. Because the output is taken straight from a flop, each result bit shows up one clock after the input bit it belongs to. A one-cycle start pulse before each word clears the machine. The data input is ignored during that pulse. A word of any length then follows, and its end needs no marker.

Top module: `serial_neg`

## Requirements
- R1: While rst_ni is low, bit_o is 0. After reset is released, the machine starts in the copy state, so the first word can follow without a start pulse.
- R2: The output bit for an input bit sampled at rising edge k is on bit_o from edge k until edge k+1. That is a latency of exactly one clock.
- R3: Input bits up to and including the first 1 of a word are reproduced unchanged on bit_o.
- R4: Every input bit after the first 1 of a word is reproduced inverted on bit_o, for the rest of the word.
- R5: When start_i is high at a rising edge, the machine returns to the copy state with output 0, whatever bit_i is. bit_o is 0 for the following cycle.
- R6: A word of all zeros produces a word of all zeros.
- R7: After a start pulse, a new word is copied up to its first 1 again, even if the previous word ended in the inverting state.
- R8: Read least significant bit first, the serial output of a word of width w (1 to 16 bits) equals the two's complement of the input word modulo 2^w. For example, 8-bit 00000110 gives 11111010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Synchronous word-start clear, active high; data ignored that cycle |
| bit_i | input | 1 | Serial input bit, least significant bit first |
| bit_o | output | 1 | Serial negated bit, one clock behind bit_i |

## Verification
Two things can fall in the same cycle: a start pulse, and a data bit that would otherwise change the state. The bench provokes this by raising start_i together with bit_i = 1, once while the machine is in the inverting state and at the head of every table word. It expects bit_o to be 0 in the next cycle. It also expects the bit after the pulse to be copied rather than inverted, which shows that the pending data bit was discarded and the sticky flag was cleared.

// File: rtl/serial_neg_pkg.sv
package serial_neg_pkg;

  // seen: a 1 has already gone out in this word; out: registered output bit
  typedef struct packed {
    logic seen;
    logic out;
  } neg_state_t;

  localparam neg_state_t NEG_IDLE = '0;

endpackage

// File: rtl/serial_neg_next.sv
module serial_neg_next
  import serial_neg_pkg::*;
(
  input  neg_state_t state_i,
  input  logic       start_i,
  input  logic       bit_i,
  output neg_state_t state_o
);

  logic seen_nxt;

  // flag turns on the cycle after the first 1 has been emitted
  assign seen_nxt = state_i.seen | state_i.out;

  always_comb begin
    if (start_i) begin
      state_o = NEG_IDLE;
    end else begin
      state_o.seen = seen_nxt;
      state_o.out  = bit_i ^ seen_nxt;
    end
  end

endmodule

// File: rtl/serial_neg_reg.sv
module serial_neg_reg
  import serial_neg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  neg_state_t state_d_i,
  output neg_state_t state_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q_o <= NEG_IDLE;
    else         state_q_o <= state_d_i;
  end

  // sticky flag may only be dropped by a clear to idle
  p_seen_clears_to_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_q_o.seen) |-> (state_q_o == NEG_IDLE))
    else $error("seen flag dropped without returning to idle");

endmodule

// File: rtl/serial_neg.sv
module serial_neg
  import serial_neg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_i,
  output logic bit_o
);

  neg_state_t state_q;
  neg_state_t state_d;

  serial_neg_next i_next (
    .state_i (state_q),
    .start_i (start_i),
    .bit_i   (bit_i),
    .state_o (state_d)
  );

  serial_neg_reg i_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_d_i (state_d),
    .state_q_o (state_q)
  );

  assign bit_o = state_q.out;

  p_start_clears_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!bit_o && !state_q.seen))
    else $error("start did not clear the machine");

  p_copy_before_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !state_q.seen && !bit_o) |=> (bit_o == $past(bit_i)))
    else $error("bit not copied before first one");

  p_invert_after_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && (state_q.seen || bit_o)) |=> (bit_o == !$past(bit_i)))
    else $error("bit not inverted after first one");

  p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && state_q.seen) |=> state_q.seen)
    else $error("seen flag lost inside a word");

endmodule

// File: tb/test_serial_neg.sv
module test_serial_neg;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic bit_i = 1'b0;
  logic bit_o;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  serial_neg i_serial_neg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .bit_i   (bit_i),
    .bit_o   (bit_o)
  );

  typedef struct packed {
    logic [4:0]  w;
    logic [15:0] v;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{5'd8,  16'h0006}, '{5'd8,  16'h0000}, '{5'd8,  16'h0080},
    '{5'd8,  16'h00ff}, '{5'd16, 16'h0001}, '{5'd16, 16'h8000},
    '{5'd16, 16'ha5a5}, '{5'd4,  16'h0008}, '{5'd1,  16'h0001},
    '{5'd1,  16'h0000}, '{5'd12, 16'h07f0}, '{5'd16, 16'hfffe}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at a falling edge, result is sampled at the next falling edge
  task automatic step(input logic s, input logic b, output logic q);
    start_i = s;
    bit_i   = b;
    @(posedge clk_i);
    @(negedge clk_i);
    q = bit_o;
  endtask

  task automatic run_word(input int w, input logic [15:0] v, output logic [15:0] got);
    logic q;
    got = '0;
    step(1'b1, 1'b1, q);  // start with data high: data must be dropped
    check("R5", {15'd0, q}, 16'd0);
    for (int i = 0; i < w; i++) begin
      step(1'b0, v[i], q);
      got[i] = q;
    end
  endtask

  function automatic logic [15:0] negate(input int w, input logic [15:0] v);
    logic [31:0] mask;
    mask = (32'h1 << w) - 32'h1;
    return (~v + 16'd1) & mask[15:0];
  endfunction

  initial begin
    logic q;
    logic [15:0] got;
    @(negedge clk_i);
    check("R1", {15'd0, bit_o}, 16'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", {15'd0, bit_o}, 16'd0);

    // no start after reset: first 1 copied, then inverted
    step(1'b0, 1'b0, q); check("R3", {15'd0, q}, 16'd0);
    step(1'b0, 1'b1, q); check("R2 R3", {15'd0, q}, 16'd1);
    step(1'b0, 1'b1, q); check("R4", {15'd0, q}, 16'd0);
    step(1'b0, 1'b0, q); check("R4", {15'd0, q}, 16'd1);

    // start collides with a data 1 while inverting
    step(1'b1, 1'b1, q); check("R5", {15'd0, q}, 16'd0);
    step(1'b0, 1'b1, q); check("R5 R7", {15'd0, q}, 16'd1);

    for (int k = 0; k < NVEC; k++) begin
      run_word(int'(VECS[k].w), VECS[k].v, got);
      check((VECS[k].v == 16'd0) ? "R6" : "R8 R3 R4", got, negate(int'(VECS[k].w), VECS[k].v));
    end

    run_word(8, 16'h00ff, got);
    check("R8", got, 16'h0001);
    run_word(8, 16'h0004, got);
    check("R7", got, 16'h00fc);
    run_word(16, 16'h0000, got);
    check("R6", got, 16'h0000);

    // reset mid-word returns output to zero at once
    step(1'b0, 1'b1, q);
    step(1'b0, 1'b0, q);
    #1 rst_ni = 1'b0;
    #1 check("R1", {15'd0, bit_o}, 16'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 1'b1, q); check("R1 R3", {15'd0, q}, 16'd1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule